// File: doc/BRIEF.md
# SD Host Register Width Adapter

This adapter sits between a host that uses the standard SD host controller register map, with byte, halfword and word accesses, and a controller core that has only 32-bit registers. A host access arrives as a request/acknowledge transaction. The adapter turns it into one or two word accesses on the native side. Sub-word writes become a read of the containing word, a lane merge and a write-back. Sub-word reads return the selected lane, zero-extended. On the way through, the adapter moves fields that the native core keeps at non-standard positions. These are the line levels in the present-state word and the DMA-select field of the host-control byte.

Some accesses need special handling. A transfer-mode halfword write is held in a shadow register and sent to the core only together with the next command write, as one word. A power-control byte write is dropped. Writes to the block-size halfword, the host-control byte and the interrupt-enable word are masked or adjusted before they reach the core. Reads of the two capability words are adjusted before they reach the host.

The parameter `BIG_ENDIAN` selects the byte order of the native data bus. `VENDOR_VER` gives the version number of the native core.

Top module: `sdreg_bridge`

## Requirements
- R1: The native address is the host address with bits [1:0] forced to zero. Size encoding is 0 = byte, 1 = halfword, 2 = word. A byte access uses byte lane addr[1:0]. A halfword access uses bits [31:16] when addr[1] is 1 and bits [15:0] otherwise. Read data is returned zero-extended in the low bits of `rdata`.
- R2: A halfword write to offset 0x0C (transfer mode) causes no native access. Its value is kept in a shadow register.
- R3: A halfword write to offset 0x0E (command) issues exactly one native write and no native read. The word written is {command value, shadow}. The shadow is zero after reset.
- R4: A word read of offset 0x24 (present state) returns the following. Bits [19:0] are unchanged. Bits [23:20] take native bits [27:24]. Bit 24 takes native bit 23. Bits [31:25] are zero.
- R5: A byte read of offset 0x28 (host control) returns the low byte of the word, except that bits [4:3] are replaced by native bits [23:22].
- R6: A byte write to offset 0x28 does the following. Byte bits [4:3] go to native bits [23:22]. Native bits [4:3] keep their old value. The other byte bits go to native bits [7:0], and any bit set in `RSVD_HC` (default 0x04, the high-speed bit) is forced to zero.
- R7: A byte write to offset 0x29 (power control) causes no native access, and the stored byte is left unchanged.
- R8: A halfword write to offset 0x04 (block size) clears bits [14:12] of the word it writes back.
- R9: A word write to offset 0x34 (interrupt enable) always sets bit 2 (block-gap enable) in the written word.
- R10: A word read of offset 0x40 sets bit 19 (ADMA2) when bit 20 (ADMA1) is set and `VENDOR_VER` is above 0x12. A word read of offset 0x44 clears bits [2:0] (SDR50, SDR104, DDR50).
- R11: All other sub-word writes do one native read, then one native write that merges the new lane. Each host request gets exactly one `ack` pulse, which follows the last native access. Word writes to other offsets pass through unchanged.
- R12: With `BIG_ENDIAN` = 1, native data is byte-swapped relative to the host value: host bits [7:0] travel on native bits [31:24].
- R13: After reset, `ack` and `nreq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Host request, held until `ack` |
| we | input | 1 | Host write enable |
| size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| addr | input | ADDR_W | Host byte address |
| wdata | input | 32 | Host write data, right-aligned |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Host read data, valid with `ack` |
| nreq | output | 1 | Native request, held until `nack` |
| nwe | output | 1 | Native write enable |
| naddr | output | ADDR_W | Native word address |
| nwdata | output | 32 | Native write data |
| nack | input | 1 | Native one-cycle completion pulse |
| nrdata | input | 32 | Native read data, valid with `nack` |

## Verification
The assertions assume a well-behaved host and a well-behaved native side. The host keeps one request outstanding, holds `req` until `ack` and drops it in the cycle `ack` is seen. Host addresses are naturally aligned to the access size. The native side pulses `nack` once for each access and never without a pending `nreq`. The bench host task and the native memory model follow these rules. All test data is loaded through the adapter's own word-write path, so the native memory has a single writer.

// File: rtl/sdreg_pkg.sv
package sdreg_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_DEC,
    S_RD,
    S_WR
  } brg_state_t;

  // standard register offsets whose handling differs
  localparam logic [7:0] OFF_BLKSZ = 8'h04;
  localparam logic [7:0] OFF_XFER  = 8'h0C;
  localparam logic [7:0] OFF_CMD   = 8'h0E;
  localparam logic [7:0] OFF_PRES  = 8'h24;
  localparam logic [7:0] OFF_HCTL  = 8'h28;
  localparam logic [7:0] OFF_PWR   = 8'h29;
  localparam logic [7:0] OFF_IEN   = 8'h34;
  localparam logic [7:0] OFF_CAP0  = 8'h40;
  localparam logic [7:0] OFF_CAP1  = 8'h44;

endpackage

// File: rtl/sdreg_lane_swap.sv
module sdreg_lane_swap #(
  parameter bit SWAP   = 1'b1,
  parameter int LANES  = 4
) (
  input  logic [8*LANES-1:0] din,
  output logic [8*LANES-1:0] dout
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (SWAP) begin : g_rev
      assign dout[8*i +: 8] = din[8*(LANES-1-i) +: 8];
    end else begin : g_str
      assign dout[8*i +: 8] = din[8*i +: 8];
    end
  end
endmodule

// File: rtl/sdreg_read_fix.sv
module sdreg_read_fix
  import sdreg_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter logic [7:0] VENDOR_VER = 8'h13
) (
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       word,
  output logic [31:0]       data
);
  localparam bit ADMA2_OK = (VENDOR_VER > 8'h12);

  logic [7:0]  lane8;
  logic [15:0] lane16;

  always_comb begin
    lane8  = word[{addr[1:0], 3'b000} +: 8];
    lane16 = addr[1] ? word[31:16] : word[15:0];
    data   = word;
    case (size)
      SZ_BYTE: begin
        data = {24'd0, lane8};
        if (addr == ADDR_W'(OFF_HCTL))
          data[4:3] = word[23:22];
      end
      SZ_HALF: data = {16'd0, lane16};
      default: begin
        if (addr == ADDR_W'(OFF_PRES))
          data = {7'd0, word[23], word[27:24], word[19:0]};
        else if (addr == ADDR_W'(OFF_CAP0)) begin
          if (word[20] && ADMA2_OK) data[19] = 1'b1;
        end else if (addr == ADDR_W'(OFF_CAP1))
          data[2:0] = 3'b000;
      end
    endcase
  end
endmodule

// File: rtl/sdreg_write_fix.sv
module sdreg_write_fix
  import sdreg_pkg::*;
#(
  parameter int         ADDR_W  = 8,
  parameter logic [7:0] RSVD_HC = 8'h04
) (
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  input  logic [31:0]       old_word,
  input  logic [15:0]       shadow,
  output logic [31:0]       new_word
);
  always_comb begin
    new_word = old_word;
    case (size)
      SZ_BYTE: begin
        if (addr == ADDR_W'(OFF_HCTL)) begin
          new_word[23:22] = wdata[4:3];
          new_word[7:0]   = {wdata[7:5], old_word[4:3], wdata[2:0]} & ~RSVD_HC;
        end else
          new_word[{addr[1:0], 3'b000} +: 8] = wdata[7:0];
      end
      SZ_HALF: begin
        if (addr == ADDR_W'(OFF_CMD))
          new_word = {wdata[15:0], shadow};
        else begin
          new_word[{addr[1], 4'b0000} +: 16] = wdata[15:0];
          if (addr == ADDR_W'(OFF_BLKSZ))
            new_word[14:12] = 3'b000;
        end
      end
      default: begin
        new_word = wdata;
        if (addr == ADDR_W'(OFF_IEN)) new_word[2] = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/sdreg_bridge.sv
module sdreg_bridge
  import sdreg_pkg::*;
#(
  parameter int         ADDR_W     = 8,
  parameter bit         BIG_ENDIAN = 1'b1,
  parameter logic [7:0] VENDOR_VER = 8'h13,
  parameter logic [7:0] RSVD_HC    = 8'h04
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req,
  input  logic              we,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic              ack,
  output logic [31:0]       rdata,
  output logic              nreq,
  output logic              nwe,
  output logic [ADDR_W-1:0] naddr,
  output logic [31:0]       nwdata,
  input  logic              nack,
  input  logic [31:0]       nrdata
);
  brg_state_t        st;
  logic              l_we;
  logic [1:0]        l_size;
  logic [ADDR_W-1:0] l_addr;
  logic [31:0]       l_wdata;
  logic [15:0]       shadow;

  logic [31:0] nat_rd_host;   // native read word in host byte order
  logic [31:0] rd_fixed;
  logic [31:0] wr_fixed;
  logic [31:0] wr_native;

  logic dec_xfer, dec_pwr, dec_direct;

  assign dec_xfer   = l_we && (l_size == SZ_HALF) && (l_addr == ADDR_W'(OFF_XFER));
  assign dec_pwr    = l_we && (l_size == SZ_BYTE) && (l_addr == ADDR_W'(OFF_PWR));
  assign dec_direct = l_we && ((l_size == SZ_WORD) ||
                      ((l_size == SZ_HALF) && (l_addr == ADDR_W'(OFF_CMD))));

  sdreg_lane_swap #(.SWAP(BIG_ENDIAN), .LANES(4)) u_rd_swap (
    .din(nrdata), .dout(nat_rd_host));

  sdreg_lane_swap #(.SWAP(BIG_ENDIAN), .LANES(4)) u_wr_swap (
    .din(wr_fixed), .dout(wr_native));

  sdreg_read_fix #(.ADDR_W(ADDR_W), .VENDOR_VER(VENDOR_VER)) u_rfix (
    .size(l_size), .addr(l_addr), .word(nat_rd_host), .data(rd_fixed));

  sdreg_write_fix #(.ADDR_W(ADDR_W), .RSVD_HC(RSVD_HC)) u_wfix (
    .size(l_size), .addr(l_addr), .wdata(l_wdata), .old_word(nat_rd_host),
    .shadow(shadow), .new_word(wr_fixed));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= S_IDLE;
      ack     <= 1'b0;
      rdata   <= '0;
      nreq    <= 1'b0;
      nwe     <= 1'b0;
      naddr   <= '0;
      nwdata  <= '0;
      shadow  <= '0;
      l_we    <= 1'b0;
      l_size  <= '0;
      l_addr  <= '0;
      l_wdata <= '0;
    end else begin
      ack <= 1'b0;
      case (st)
        S_IDLE: begin
          if (req) begin
            l_we    <= we;
            l_size  <= size;
            l_addr  <= addr;
            l_wdata <= wdata;
            st      <= S_DEC;
          end
        end
        S_DEC: begin
          naddr <= {l_addr[ADDR_W-1:2], 2'b00};
          if (dec_xfer) begin
            shadow <= l_wdata[15:0];
            ack    <= 1'b1;
            st     <= S_IDLE;
          end else if (dec_pwr) begin
            ack <= 1'b1;
            st  <= S_IDLE;
          end else if (dec_direct) begin
            nreq   <= 1'b1;
            nwe    <= 1'b1;
            nwdata <= wr_native;
            st     <= S_WR;
          end else begin
            nreq <= 1'b1;
            nwe  <= 1'b0;
            st   <= S_RD;
          end
        end
        S_RD: begin
          if (nack) begin
            if (l_we) begin
              nwe    <= 1'b1;
              nwdata <= wr_native;
              st     <= S_WR;
            end else begin
              nreq  <= 1'b0;
              rdata <= rd_fixed;
              ack   <= 1'b1;
              st    <= S_IDLE;
            end
          end
        end
        default: begin
          if (nack) begin
            nreq <= 1'b0;
            nwe  <= 1'b0;
            ack  <= 1'b1;
            st   <= S_IDLE;
          end
        end
      endcase
    end
  end

  // R1: native accesses are always word aligned
  p_word_aligned_r1: assert property (@(posedge clk) disable iff (rst)
    nreq |-> (naddr[1:0] == 2'b00));

  // R2: a transfer-mode write finishes without touching the native bus
  p_xfer_no_bus_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEC && dec_xfer) |=> (!nreq && ack));

  // R3: a command write goes straight to a native write
  p_cmd_direct_r3: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEC && l_we && l_size == SZ_HALF && l_addr == ADDR_W'(OFF_CMD))
      |=> (nreq && nwe));

  // R7: a power-control write never reaches the native bus
  p_pwr_no_bus_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_DEC && dec_pwr) |=> (!nreq && ack));

  // R11: read of a merge is followed directly by the write-back
  p_rmw_order_r11: assert property (@(posedge clk) disable iff (rst)
    (st == S_RD && nack && l_we) |=> (nreq && nwe));

  // R11: a pending native request holds its address
  p_nreq_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (nreq && !nack) |=> (nreq && $stable(naddr)));

  // R11: one acknowledge per request, one cycle wide
  p_ack_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R13: nothing pending in the cycle after reset
  p_reset_quiet_r13: assert property (@(posedge clk)
    $past(rst) |-> (!ack && !nreq));
endmodule

// File: tb/sdreg_bridge_test.sv
module sdreg_bridge_test;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0, we = 1'b0;
  logic [1:0]  size = 2'd0;
  logic [7:0]  addr = 8'd0;
  logic [31:0] wdata = 32'd0;
  logic        ack;
  logic [31:0] rdata;
  logic        nreq, nwe;
  logic [7:0]  naddr;
  logic [31:0] nwdata;
  logic        nack;
  logic [31:0] nrdata;

  always #2 clk = ~clk;   // 250 MHz

  sdreg_bridge #(.ADDR_W(AW), .BIG_ENDIAN(1'b1), .VENDOR_VER(8'h13),
                 .RSVD_HC(8'h04)) uut (
    .clk(clk), .rst(rst), .req(req), .we(we), .size(size), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata), .nreq(nreq), .nwe(nwe),
    .naddr(naddr), .nwdata(nwdata), .nack(nack), .nrdata(nrdata));

  // native memory model (raw, native byte order)
  logic [31:0] mem_raw [64];
  int nwr_cnt, nrd_cnt;
  always @(posedge clk) begin
    if (rst) begin
      nack <= 1'b0; nrdata <= 32'd0; nwr_cnt <= 0; nrd_cnt <= 0;
      for (int i = 0; i < 64; i++) mem_raw[i] <= 32'd0;
    end else if (nreq && !nack) begin
      nack <= 1'b1;
      if (nwe) begin
        mem_raw[naddr[7:2]] <= nwdata;
        nwr_cnt <= nwr_cnt + 1;
      end else begin
        nrdata  <= mem_raw[naddr[7:2]];
        nrd_cnt <= nrd_cnt + 1;
      end
    end else nack <= 1'b0;
  end

  int checks = 0, fails = 0;
  bit busy = 1'b0;
  bit done = 1'b0;
  logic [31:0] ref_mem [64];
  logic [15:0] ref_shadow = 16'd0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] bswap(input logic [31:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // compared on every clock: no ack or native request outside a transaction
  always @(negedge clk) begin
    if (!rst && !busy && !done) begin
      check(!ack,  "R11 stray ack",  {31'd0, ack},  32'd0);
      check(!nreq, "R11 stray nreq", {31'd0, nreq}, 32'd0);
    end
  end

  function automatic logic [31:0] exp_read(input logic [1:0] sz,
      input logic [7:0] a, input logic [31:0] w);
    logic [31:0] r;
    int sh;
    if (sz == 2'd0) begin
      sh = 8 * int'(a[1:0]);
      r = (w >> sh) & 32'hFF;
      if (a == 8'h28) begin r[3] = w[22]; r[4] = w[23]; end
    end else if (sz == 2'd1) begin
      sh = a[1] ? 16 : 0;
      r = (w >> sh) & 32'hFFFF;
    end else if (a == 8'h24) begin
      r = w & 32'h000F_FFFF;
      for (int b = 0; b < 4; b++) r[20+b] = w[24+b];
      r[24] = w[23];
    end else if (a == 8'h40) begin
      r = w;
      if (w[20]) r[19] = 1'b1;   // vendor version 0x13 > 0x12
    end else if (a == 8'h44) begin
      r = w & ~32'h7;
    end else r = w;
    return r;
  endfunction

  // returns {write_issued, word}
  function automatic logic [32:0] exp_write(input logic [1:0] sz,
      input logic [7:0] a, input logic [31:0] d, input logic [31:0] old,
      input logic [15:0] shd);
    logic [31:0] r;
    int sh;
    r = old;
    if (sz == 2'd2) begin
      r = d;
      if (a == 8'h34) r = r | 32'h4;
    end else if (sz == 2'd1) begin
      if (a == 8'h0C) return {1'b0, old};
      if (a == 8'h0E) return {1'b1, d[15:0], shd};
      sh = a[1] ? 16 : 0;
      r = (old & ~(32'hFFFF << sh)) | ((d & 32'hFFFF) << sh);
      if (a == 8'h04) r = r & ~32'h0000_7000;
    end else begin
      if (a == 8'h29) return {1'b0, old};
      if (a == 8'h28) begin
        r[23] = d[4]; r[22] = d[3];
        r[7:5] = d[7:5]; r[2:0] = d[2:0];
        r[2] = 1'b0;    // reserved high-speed bit
      end else begin
        sh = 8 * int'(a[1:0]);
        r = (old & ~(32'hFF << sh)) | ((d & 32'hFF) << sh);
      end
    end
    return {1'b1, r};
  endfunction

  task automatic access(input bit w, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] d, input string tag);
    int wr0, rd0, exp_wr, exp_rd;
    logic [31:0] old, expw;
    logic [32:0] ew;
    old = ref_mem[a[7:2]];
    wr0 = nwr_cnt; rd0 = nrd_cnt;
    busy = 1'b1;
    @(negedge clk);
    req = 1'b1; we = w; size = sz; addr = a; wdata = d;
    do @(negedge clk); while (!ack);
    req = 1'b0;
    if (w) begin
      ew = exp_write(sz, a, d, old, ref_shadow);
      exp_wr = ew[32] ? 1 : 0;
      exp_rd = (!ew[32] || sz == 2'd2 || (sz == 2'd1 && a == 8'h0E)) ? 0 : 1;
      if (ew[32]) ref_mem[a[7:2]] = ew[31:0];
      if (sz == 2'd1 && a == 8'h0C) ref_shadow = d[15:0];
      expw = bswap(ref_mem[a[7:2]]);
      check(mem_raw[a[7:2]] === expw, tag, mem_raw[a[7:2]], expw);
    end else begin
      exp_wr = 0; exp_rd = 1;
      check(rdata === exp_read(sz, a, old), tag, rdata, exp_read(sz, a, old));
    end
    check(nwr_cnt - wr0 == exp_wr, {tag, " native writes"}, 32'(nwr_cnt - wr0), 32'(exp_wr));
    check(nrd_cnt - rd0 == exp_rd, {tag, " native reads"}, 32'(nrd_cnt - rd0), 32'(exp_rd));
    @(negedge clk);
    check(!ack, {tag, " R11 single ack"}, {31'd0, ack}, 32'd0);
    busy = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) ref_mem[i] = 32'd0;
    repeat (3) @(negedge clk);
    check(!ack && !nreq, "R13 reset outputs", {30'd0, ack, nreq}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // R3: command before any transfer-mode write uses zero shadow
    access(1, 2'd1, 8'h0E, 32'h1A3B, "R3 cmd with reset shadow");
    // R2: transfer-mode write held back
    access(1, 2'd1, 8'h0C, 32'h0023, "R2 xfer shadowed");
    access(1, 2'd1, 8'h0E, 32'h0C52, "R3 cmd merges shadow");
    // preload through the word path (R11 pass-through, R12 byte order)
    access(1, 2'd2, 8'h30, 32'h1122_3344, "R11 word write");
    check(mem_raw[12] === 32'h4433_2211, "R12 native byte order", mem_raw[12], 32'h4433_2211);
    access(1, 2'd2, 8'h24, 32'hA58F_1234, "R11 preload present");
    access(0, 2'd2, 8'h24, 32'd0, "R4 present remap");
    access(1, 2'd2, 8'h24, 32'h0600_0000, "R11 preload present b");
    access(0, 2'd2, 8'h24, 32'd0, "R4 present remap b");
    access(1, 2'd2, 8'h28, 32'h0080_0008, "R11 preload hctl");
    access(0, 2'd0, 8'h28, 32'd0, "R5 hctl dma read");
    access(1, 2'd0, 8'h28, 32'hFF, "R6 hctl write");
    access(0, 2'd0, 8'h28, 32'd0, "R5 hctl read after write");
    access(1, 2'd0, 8'h28, 32'h07, "R6 hctl write low");
    access(1, 2'd0, 8'h29, 32'h5A, "R7 power write dropped");
    access(0, 2'd0, 8'h29, 32'd0, "R7 power byte unchanged");
    access(1, 2'd2, 8'h04, 32'h1234_5678, "R11 preload blksz");
    access(1, 2'd1, 8'h04, 32'hFFFF, "R8 boundary cleared");
    access(1, 2'd1, 8'h06, 32'hBEEF, "R1 upper half merge");
    access(1, 2'd0, 8'h02, 32'h3C, "R1 byte lane 2 merge");
    access(0, 2'd0, 8'h01, 32'd0, "R1 byte lane 1 read");
    access(0, 2'd0, 8'h03, 32'd0, "R1 byte lane 3 read");
    access(0, 2'd1, 8'h06, 32'd0, "R1 upper half read");
    access(1, 2'd2, 8'h34, 32'h0000_0000, "R9 ien block gap");
    access(1, 2'd2, 8'h34, 32'hFFFF_00F0, "R9 ien keeps bits");
    access(1, 2'd2, 8'h40, 32'h0010_0000, "R11 preload caps adma1");
    access(0, 2'd2, 8'h40, 32'd0, "R10 adma2 added");
    access(1, 2'd2, 8'h40, 32'h0000_00FF, "R11 preload caps none");
    access(0, 2'd2, 8'h40, 32'd0, "R10 no adma1");
    access(1, 2'd2, 8'h44, 32'h8000_0007, "R11 preload caps1");
    access(0, 2'd2, 8'h44, 32'd0, "R10 uhs bits cleared");
    access(1, 2'd1, 8'h0C, 32'hFFFF, "R2 xfer shadow again");
    access(1, 2'd1, 8'h0E, 32'h0001, "R3 cmd second shadow");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule